// File: doc/BRIEF.md
# Bit-Serial Radix-2 Montgomery Multiplier

This block multiplies two operands modulo an odd modulus in Montgomery form. It returns S = A·B·R⁻¹ mod M with R = 2^(N+3), where N is the operand width. A start pulse captures the three operands. The block then consumes one bit of B per clock, lowest bit first. In each clock cycle it conditionally adds the full-width A, then conditionally adds M so that the sum is even, and halves the result. The computation of the partial sum, the addition of M, the halving and the shift of B all take place in a single clock cycle.

The loop runs three iterations more than B has bits. The result therefore stays below M + A with no final subtraction, so it can be fed straight back in as an operand of an exponentiation chain. Precomputation of the conversion constant R² mod M is left to the user, and so is any final reduction below M. An optional variant precomputes A + M at start, so that each iteration needs only one full-width adder.

Top module: `mont_bitser_mul`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `done_o` is 0 and `s_o` is 0.
- R2: With M odd, the result is S = (A·B + Q·M) / 2^(N+3). Here Q is the unique value in [0, 2^(N+3)) that makes the numerator divisible by 2^(N+3), which gives S ≡ A·B·2^-(N+3) (mod M).
- R3: At completion, S < M + A. For A < M this means S < 2M, and S always fits in the N+1 bit output.
- R4: A start sampled high on a rising edge while the block is idle begins an operation. `done_o` is high in the cycle that follows the (N+3)-th rising edge after that edge.
- R5: `done_o` is high for exactly one cycle per operation.
- R6: Between completion and the next accepted start, `s_o` holds its value, whatever the operand inputs do.
- R7: While an operation is running, the block ignores `start` and ignores changes on `a_i`, `b_i` and `m_i`. The running result and its latency are unaffected.
- R8: A start presented in the cycle where `done_o` is high is accepted, so operations can run back to back.
- R9: The single-adder variant (`PRESUM` = 1) produces the same result, at the same time, as the two-adder variant (`PRESUM` = 0).
- R10: If A = 0 or B = 0, the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins an operation when the block is idle |
| a_i | input | WIDTH | Multiplicand A |
| b_i | input | WIDTH | Multiplier B, scanned from the lowest bit |
| m_i | input | WIDTH | Odd modulus M |
| s_o | output | WIDTH+1 | Montgomery product |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result is due in the cycle after the 35th rising edge that follows the accepting edge, given the default width of 32. The bench drives `start` on a falling edge and then counts falling edges after the accepting rising edge. It reads `done_o` and `s_o` only at falling edges, so the measured latency must equal 35 exactly, and the product is compared with a value the bench computes through an independent Montgomery-quotient formula. It probes the hold and disturbance cases at set cycle offsets: inside the run, and several cycles after `done_o`. Two instances, one of each adder variant, run on the same stimulus and are checked against each other in the same cycle.

// File: rtl/mont_pkg.sv
package mont_pkg;

   // Addend picked in one iteration by the single-adder variant
   typedef enum logic [1:0] {
      ADD_NONE = 2'b00,
      ADD_MOD  = 2'b01,
      ADD_MULT = 2'b10,
      ADD_BOTH = 2'b11
   } addend_sel_e;

   // Total loop passes for an operand width and a count of extra passes
   function automatic int unsigned iter_total(input int unsigned width,
                                              input int unsigned extra);
      return width + extra + 1;
   endfunction

endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl #(
   parameter int unsigned ITERS = 35
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic busy,
   output logic done_o
);
   localparam int unsigned CW = $clog2(ITERS + 1);
   localparam logic [CW-1:0] LAST_LOAD = CW'(ITERS - 1);

   logic [CW-1:0] pass_cnt;

   assign load = start & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         pass_cnt <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (load) begin
            busy     <= 1'b1;
            pass_cnt <= LAST_LOAD;
         end else if (busy) begin
            if (pass_cnt == '0) begin
               busy   <= 1'b0;
               done_o <= 1'b1;
            end else begin
               pass_cnt <= pass_cnt - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mont_step.sv
module mont_step
   import mont_pkg::*;
#(
   parameter int unsigned IW     = 35,
   parameter bit          PRESUM = 1'b0
) (
   input  logic [IW-1:0] s_cur,
   input  logic [IW-1:0] a_op,
   input  logic [IW-1:0] m_op,
   input  logic [IW-1:0] am_op,
   input  logic          b_bit,
   output logic [IW-1:0] s_nxt
);
   logic [IW-1:0] total;
   logic          unused_lsb;

   generate
      if (PRESUM) begin : g_one_adder
         // parity of S + b*A decides the modulus add without forming the sum
         logic        q_odd;
         addend_sel_e sel;
         logic [IW-1:0] addend;
         assign q_odd = s_cur[0] ^ (b_bit & a_op[0]);
         assign sel   = addend_sel_e'({b_bit, q_odd});
         always_comb begin
            case (sel)
               ADD_NONE: addend = '0;
               ADD_MOD:  addend = m_op;
               ADD_MULT: addend = a_op;
               default:  addend = am_op;
            endcase
         end
         assign total = s_cur + addend;
      end else begin : g_two_adder
         logic [IW-1:0] q_sum;
         logic          unused_am;
         assign unused_am = |am_op;
         assign q_sum = s_cur + (b_bit ? a_op : '0);
         assign total = q_sum + (q_sum[0] ? m_op : '0);
      end
   endgenerate

   assign unused_lsb = total[0];
   assign s_nxt      = {1'b0, total[IW-1:1]};
endmodule

// File: rtl/mont_datapath.sv
module mont_datapath #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned IW     = 35,
   parameter bit          PRESUM = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [WIDTH-1:0] m_i,
   output logic [WIDTH:0]   s_o,
   output logic [WIDTH-1:0] a_cap,
   output logic [WIDTH-1:0] m_cap
);
   logic [IW-1:0]    s_q;
   logic [IW-1:0]    a_q;
   logic [IW-1:0]    m_q;
   logic [IW-1:0]    am_q;
   logic [WIDTH-1:0] b_q;
   logic [IW-1:0]    s_step;
   logic             unused_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_q <= '0;
         a_q <= '0;
         m_q <= '0;
         b_q <= '0;
      end else if (load) begin
         s_q <= '0;
         a_q <= IW'(a_i);
         m_q <= IW'(m_i);
         b_q <= b_i;
      end else if (step) begin
         s_q <= s_step;
         b_q <= b_q >> 1;
      end
   end

   generate
      if (PRESUM) begin : g_am_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               am_q <= '0;
            end else if (load) begin
               am_q <= IW'(a_i) + IW'(m_i);
            end
         end
      end else begin : g_am_none
         assign am_q = '0;
      end
   endgenerate

   mont_step #(
      .IW     (IW),
      .PRESUM (PRESUM)
   ) u_step (
      .s_cur (s_q),
      .a_op  (a_q),
      .m_op  (m_q),
      .am_op (am_q),
      .b_bit (b_q[0]),
      .s_nxt (s_step)
   );

   assign s_o       = s_q[WIDTH:0];
   assign a_cap     = a_q[WIDTH-1:0];
   assign m_cap     = m_q[WIDTH-1:0];
   assign unused_hi = |{s_q[IW-1:WIDTH+1], a_q[IW-1:WIDTH], m_q[IW-1:WIDTH]};
endmodule

// File: rtl/mont_bitser_mul.sv
module mont_bitser_mul
   import mont_pkg::*;
#(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned EXTRA_ITERS = 2,
   parameter int unsigned GUARD_BITS  = 3,
   parameter bit          PRESUM      = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [WIDTH-1:0] m_i,
   output logic [WIDTH:0]   s_o,
   output logic             done_o
);
   localparam int unsigned ITERS = iter_total(WIDTH, EXTRA_ITERS);
   localparam int unsigned IW    = WIDTH + GUARD_BITS;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("mont_bitser_mul: WIDTH must be at least 2");
      end
      if (GUARD_BITS < 3) begin : g_bad_guard
         $error("mont_bitser_mul: GUARD_BITS must be at least 3");
      end
      if (EXTRA_ITERS > 16) begin : g_bad_extra
         $error("mont_bitser_mul: EXTRA_ITERS above 16 only adds latency");
      end
   endgenerate

   logic             load;
   logic             run_busy;
   logic [WIDTH-1:0] a_cap;
   logic [WIDTH-1:0] m_cap;

   mont_ctrl #(
      .ITERS (ITERS)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .load   (load),
      .busy   (run_busy),
      .done_o (done_o)
   );

   mont_datapath #(
      .WIDTH  (WIDTH),
      .IW     (IW),
      .PRESUM (PRESUM)
   ) u_dp (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (run_busy),
      .a_i   (a_i),
      .b_i   (b_i),
      .m_i   (m_i),
      .s_o   (s_o),
      .a_cap (a_cap),
      .m_cap (m_cap)
   );
endmodule

// File: rtl/mont_bitser_mul_chk.sv
module mont_bitser_mul_chk #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned ITERS = 35
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             done_o,
   input logic             busy,
   input logic [WIDTH:0]   s_o,
   input logic [WIDTH-1:0] a_op,
   input logic [WIDTH-1:0] m_op
);
   localparam int unsigned CW = $clog2(ITERS + 1);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (start && !busy) begin
         run_cnt <= '0;
      end else if (busy) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_cnt == CW'(ITERS))); // R4

   AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((WIDTH+2)'(s_o) < ((WIDTH+2)'(a_op) + (WIDTH+2)'(m_op)))); // R3

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(s_o)); // R6

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (run_cnt == CW'($past(run_cnt) + 1'b1))); // R7

   AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && start) |=> (busy && run_cnt == '0)); // R8
endmodule

bind mont_bitser_mul mont_bitser_mul_chk #(
   .WIDTH (WIDTH),
   .ITERS (ITERS)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .done_o (done_o),
   .busy   (run_busy),
   .s_o    (s_o),
   .a_op   (a_cap),
   .m_op   (m_cap)
);

// File: tb/mont_bitser_mul_bench.sv
`timescale 1ns/1ps
module mont_bitser_mul_bench;
   localparam int unsigned N     = 32;
   localparam int unsigned ITERS = N + 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [N-1:0] a_i = '0;
   logic [N-1:0] b_i = '0;
   logic [N-1:0] m_i = '0;
   logic [N:0]   s_two;
   logic [N:0]   s_one;
   logic         done_two;
   logic         done_one;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   mont_bitser_mul #(.WIDTH(N), .PRESUM(1'b0)) u_mont_bitser_mul (
      .clk(clk), .rst_n(rst_n), .start(start), .a_i(a_i), .b_i(b_i),
      .m_i(m_i), .s_o(s_two), .done_o(done_two));

   mont_bitser_mul #(.WIDTH(N), .PRESUM(1'b1)) u_mont_bitser_mul_presum (
      .clk(clk), .rst_n(rst_n), .start(start), .a_i(a_i), .b_i(b_i),
      .m_i(m_i), .s_o(s_one), .done_o(done_one));

   // Montgomery product from the quotient formula: Q = -A*B*M^-1 mod 2^k
   function automatic logic [127:0] ref_mont(input logic [127:0] a,
                                             input logic [127:0] b,
                                             input logic [127:0] m);
      logic [127:0] mask;
      logic [127:0] inv;
      logic [127:0] ab;
      logic [127:0] q;
      mask = (128'd1 << ITERS) - 128'd1;
      inv  = m;
      for (int i = 0; i < 6; i++) begin
         inv = (inv * (128'd2 - ((m * inv) & mask))) & mask;
      end
      ab = a * b;
      q  = ((((~ab) + 128'd1) & mask) * inv) & mask;
      return (ab + q * m) >> ITERS;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Launch one operation; optionally disturb inputs mid-run.
   task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [N-1:0] m, input bit disturb,
                         input string req);
      logic [127:0] exp;
      int lat;
      exp = ref_mont(128'(a), 128'(b), 128'(m));
      a_i = a; b_i = b; m_i = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      for (int c = 1; c <= ITERS + 8; c++) begin
         @(negedge clk);
         if (disturb && c == 10) begin
            start = 1'b1; a_i = $urandom; b_i = $urandom; m_i = $urandom | 1;
         end
         if (disturb && c == 11) start = 1'b0;
         if (done_two) begin
            lat = c;
            break;
         end
      end
      check(lat == ITERS, "R4", "latency", 128'(lat), 128'(ITERS));
      check(128'(s_two) == exp, req, "product", 128'(s_two), exp);
      check(s_one == s_two && done_one == done_two, "R9", "variant match",
            128'(s_one), 128'(s_two));
      check(129'(s_two) < 129'(a) + 129'(m), "R3", "bound",
            128'(s_two), 128'(a) + 128'(m));
   endtask

   initial begin
      for (int cyc = 0; cyc < 150000; cyc++) begin
         @(posedge clk);
         if (finished) break;
      end
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [N:0] held;
      logic [N-1:0] m, a, b;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check(done_two == 1'b0 && s_two == '0, "R1", "in reset", 128'(s_two), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done_two == 1'b0 && s_two == '0 && s_one == '0, "R1", "after reset",
            128'(s_two), 0);

      // directed corners
      run_op(32'd0, 32'h1234_5677, 32'hFFFF_FFFB, 1'b0, "R10");
      check(s_two == '0, "R10", "zero A", 128'(s_two), 0);
      @(negedge clk);
      check(done_two == 1'b0, "R5", "pulse width", 128'(done_two), 0);
      run_op(32'h89AB_CDEF, 32'd0, 32'h8000_0001, 1'b0, "R10");
      check(s_two == '0, "R10", "zero B", 128'(s_two), 0);
      run_op(32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R2");
      run_op(32'd1, 32'd1, 32'd3, 1'b0, "R2");
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, 1'b0, "R2");
      // back-to-back: next start is driven in the done cycle
      run_op(32'h0F0F_0F0F, 32'h7777_1111, 32'hC000_0003, 1'b0, "R8");

      // hold after completion while inputs move
      held = s_two;
      repeat (5) @(negedge clk);
      a_i = $urandom; b_i = $urandom; m_i = $urandom | 1;
      repeat (3) @(negedge clk);
      check(s_two == held && done_two == 1'b0, "R6", "hold", 128'(s_two),
            128'(held));

      // start and operand changes during a run
      run_op(32'h1357_9BDF, 32'h2468_ACE1, 32'hF123_4567, 1'b1, "R7");
      @(negedge clk);
      check(done_two == 1'b0, "R7", "no second done", 128'(done_two), 0);

      for (int i = 0; i < 200; i++) begin
         m = $urandom | 32'd1;
         if (i % 2 == 0) m = m | 32'h8000_0000;
         if (i % 3 == 0) begin
            a = $urandom % m; b = $urandom % m;
         end else begin
            a = $urandom; b = $urandom;
         end
         run_op(a, b, m, (i % 17 == 5), "R2");
         if (i % 4 == 0) @(negedge clk);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule